// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR-style flash. It decides when the flash's embedded program or erase algorithm has finished, and whether it finished cleanly. Software or a sequencer first issues the flash command on its own. It then pulses `start` with the kind of operation, the address to poll and, for a program, the byte that was meant to be stored. The poller then reads that address over and over through a one-at-a-time read port and watches two bits of each returned byte:

- bit 6 is the toggle flag. It flips on every read while the flash is busy.
- bit 5 is the error flag.

Completion means two back-to-back reads return the same bit 6. If the error flag shows up while bit 6 is still flipping, the block takes two more reads before it decides. If bit 6 has settled in those two reads, the operation is complete; otherwise it has failed. After a completed program, one more read compares the whole byte with the intended value.

The read port is a request/response channel:

- **Request side.** `rd_req_valid` rises with `rd_addr`. Both stay unchanged until a cycle in which `rd_req_ready` is high; that cycle transfers the request. The flash side may hold `rd_req_ready` low for any number of cycles to apply back-pressure.
- **Response side.** The responder must return exactly one `rd_rsp_valid` pulse, carrying `rd_rsp_data`, for each transferred request. It may insert any number of cycles before that pulse.
- **Pacing.** The poller never has more than one read outstanding.

The result appears on `done` with exactly one of `pass` or `fail`. It holds until the next accepted `start`. A poll-count ceiling turns a toggle that never stops into a failure.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `rd_req_valid` are all low.
- R2: A `start` pulse while idle is accepted. On the next cycle `busy` is high and a read request is raised with `rd_addr` equal to the captured `start_addr`. Every read of the operation uses that address. No new request is raised while a transferred request still awaits its response.
- R3: While `rd_req_valid` is high and `rd_req_ready` is low, the request and `rd_addr` are held unchanged on the next cycle.
- R4: For an erase (`start_op`=1), the result is pass as soon as a status read returns the same bit 6 as the status read just before it. No further read follows.
- R5: For a program (`start_op`=0), once completion is reached the poller makes exactly one more read. It passes if all 8 bits of that read equal `start_data` and fails otherwise.
- R6: If a status read shows bit 6 changed and bit 5 equal to 1, two more reads follow. If their bit 6 values match, this counts as completion, as in R4/R5. If they differ, the result is fail.
- R7: In the main poll loop, at most `MAX_POLLS` status reads are made. If read number `MAX_POLLS` still shows bit 6 changed with bit 5 at 0, the result is fail. A match on that very read still counts as completion.
- R8: The result is reported one cycle after the deciding response, with `done` high and exactly one of `pass`/`fail` high. All three hold until the next accepted `start`. While `done` is low, `pass` and `fail` are low.
- R9: A `start` pulse while `busy` is high is ignored. The address in use and the outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| start_op | input | 1 | 0 = program, 1 = erase |
| start_addr | input | ADDR_W | Address to poll |
| start_data | input | 8 | Intended byte for a program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result available |
| pass | output | 1 | Operation completed correctly |
| fail | output | 1 | Error, verify mismatch or poll ceiling reached |
| rd_req_valid | output | 1 | Read request present |
| rd_req_ready | input | 1 | Flash side accepts the request |
| rd_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read data present, one pulse per request |
| rd_rsp_data | input | 8 | Read data |

## Verification
The bench builds the poller with `MAX_POLLS` = 8 and `ADDR_W` = 16. A ceiling of 8 lets a never-settling toggle run out the budget within a handful of reads. It also makes the boundary reachable where the eighth read is the first stable one. The bench's responder adds two cycles of response delay and can stall the request side on alternate cycles. This exercises the hold rules on the request channel and a `start` pulse that lands mid-operation.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  localparam int DATA_W = 8;
  localparam int TGL_BIT = 6;
  localparam int ERR_BIT = 5;

  typedef enum logic [1:0] {BUS_IDLE, BUS_ISSUE, BUS_WAIT} bus_st_e;
  typedef enum logic [2:0] {PH_FIRST, PH_POLL, PH_CHK_A, PH_CHK_B, PH_VERIFY} phase_e;
  typedef enum logic [1:0] {ACT_READ, ACT_PASS, ACT_FAIL} act_e;
endpackage

// File: rtl/ftp_budget.sv
module ftp_budget #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_V = CW'(MAX_POLLS - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // High while the response being judged is read number MAX_POLLS
  assign last = (cnt == LAST_V);
endmodule

// File: rtl/ftp_judge.sv
module ftp_judge import ftp_pkg::*; (
  input  phase_e            ph,
  input  logic              is_prog,
  input  logic              prev_t,
  input  logic              budget_last,
  input  logic [DATA_W-1:0] rsp,
  input  logic [DATA_W-1:0] exp_byte,
  output act_e              act,
  output phase_e            nxt_ph
);
  logic settled, err;
  act_e   fin_act;
  phase_e fin_ph;

  assign settled = (rsp[TGL_BIT] == prev_t);
  assign err     = rsp[ERR_BIT];

  // Action taken once the toggle flag is judged settled
  always_comb begin
    if (is_prog) begin
      fin_act = ACT_READ;
      fin_ph  = PH_VERIFY;
    end else begin
      fin_act = ACT_PASS;
      fin_ph  = PH_FIRST;
    end
  end

  always_comb begin
    act    = ACT_READ;
    nxt_ph = ph;
    unique case (ph)
      PH_FIRST: nxt_ph = PH_POLL;
      PH_POLL: begin
        if (settled) begin
          act    = fin_act;
          nxt_ph = fin_ph;
        end else if (err) begin
          nxt_ph = PH_CHK_A;
        end else if (budget_last) begin
          act = ACT_FAIL;
        end
      end
      PH_CHK_A: nxt_ph = PH_CHK_B;
      PH_CHK_B: begin
        if (settled) begin
          act    = fin_act;
          nxt_ph = fin_ph;
        end else begin
          act = ACT_FAIL;
        end
      end
      PH_VERIFY: act = (rsp == exp_byte) ? ACT_PASS : ACT_FAIL;
      default: act = ACT_FAIL;
    endcase
  end
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller import ftp_pkg::*; #(
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data
);
  bus_st_e           st;
  phase_e            ph, nxt_ph;
  act_e              act;
  logic              is_prog, prev_t, budget_last;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              take, accept, main_rsp;

  assign accept   = (st == BUS_IDLE) && start;
  assign take     = (st == BUS_WAIT) && rd_rsp_valid;
  assign main_rsp = take && ((ph == PH_FIRST) || (ph == PH_POLL));

  ftp_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(main_rsp), .last(budget_last)
  );

  ftp_judge u_judge (
    .ph(ph), .is_prog(is_prog), .prev_t(prev_t), .budget_last(budget_last),
    .rsp(rd_rsp_data), .exp_byte(exp_q), .act(act), .nxt_ph(nxt_ph)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BUS_IDLE;
      ph      <= PH_FIRST;
      is_prog <= 1'b0;
      prev_t  <= 1'b0;
      addr_q  <= '0;
      exp_q   <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      unique case (st)
        BUS_IDLE: if (start) begin
          st      <= BUS_ISSUE;
          ph      <= PH_FIRST;
          is_prog <= ~start_op;
          addr_q  <= start_addr;
          exp_q   <= start_data;
          done    <= 1'b0;
          pass    <= 1'b0;
          fail    <= 1'b0;
        end
        BUS_ISSUE: if (rd_req_ready) st <= BUS_WAIT;
        BUS_WAIT: if (rd_rsp_valid) begin
          prev_t <= rd_rsp_data[TGL_BIT];
          unique case (act)
            ACT_READ: begin
              st <= BUS_ISSUE;
              ph <= nxt_ph;
            end
            ACT_PASS: begin
              st   <= BUS_IDLE;
              done <= 1'b1;
              pass <= 1'b1;
            end
            default: begin
              st   <= BUS_IDLE;
              done <= 1'b1;
              fail <= 1'b1;
            end
          endcase
        end
        default: st <= BUS_IDLE;
      endcase
    end
  end

  assign busy         = (st != BUS_IDLE);
  assign rd_req_valid = (st == BUS_ISSUE);
  assign rd_addr      = addr_q;
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr
);
  a_r1_not_both: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req_valid);
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
  a_r2_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(rd_addr)));
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass != fail));
  a_r8_no_early: assert property (@(posedge clk) disable iff (!rst_n) !done |-> (!pass && !fail));
  a_r8_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail)));
endmodule

bind flash_toggle_poller ftp_checker #(.ADDR_W(ADDR_W)) u_ftp_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr)
);

// File: tb/flash_toggle_poller_test.sv
module flash_toggle_poller_test;
  localparam int AW = 16;
  localparam int MAXP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, start_op = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    start_data = '0;
  logic          busy, done, pass, fail, rd_req_valid;
  logic          rd_req_ready = 1'b1;
  logic [AW-1:0] rd_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [7:0]    rd_rsp_data = '0;

  always #5 clk = ~clk;

  flash_toggle_poller #(.ADDR_W(AW), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .start_addr(start_addr), .start_data(start_data), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  int vectors = 0, errors = 0, cyc = 0, reads = 0;
  logic [7:0] flash_q[$];
  bit stall = 0, hs_seen = 0, finished = 0;
  int lat_left = -1;

  // ---------------- reference model (behavioural) ----------------
  int m_st = 0;      // 0 idle, 1 request up, 2 awaiting response
  int m_ph = 0;      // 0 first, 1 poll, 2 recheck A, 3 recheck B, 4 verify
  int m_cnt = 0;
  bit m_prog = 0, m_prev = 0, m_done = 0, m_pass = 0, m_fail = 0;
  logic [AW-1:0] m_addr = '0;
  logic [7:0] m_exp = '0;

  task automatic m_finish(bit ok);
    m_st = 0; m_done = 1; m_pass = ok; m_fail = !ok;
  endtask

  task automatic m_settled();
    if (m_prog) begin m_ph = 4; m_st = 1; end
    else m_finish(1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_pass = 0; m_fail = 0;
    end else if (m_st == 0) begin
      if (start) begin
        m_st = 1; m_ph = 0; m_cnt = 0; m_prog = !start_op;
        m_addr = start_addr; m_exp = start_data;
        m_done = 0; m_pass = 0; m_fail = 0;
      end
    end else if (m_st == 1) begin
      if (rd_req_ready) m_st = 2;
    end else if (rd_rsp_valid) begin
      bit t, e;
      t = rd_rsp_data[6]; e = rd_rsp_data[5];
      m_st = 1;
      case (m_ph)
        0: begin m_cnt = 1; m_ph = 1; end
        1: begin
          m_cnt++;
          if (t == m_prev) m_settled();
          else if (e) m_ph = 2;
          else if (m_cnt >= MAXP) m_finish(0);
        end
        2: m_ph = 3;
        3: if (t == m_prev) m_settled(); else m_finish(0);
        default: m_finish(rd_rsp_data == m_exp);
      endcase
      m_prev = t;
    end
  end

  // handshake observation for the responder and read count
  always @(posedge clk) begin
    if (rst_n && rd_req_valid && rd_req_ready) begin
      hs_seen <= 1'b1;
      reads   <= reads + 1;
    end else begin
      hs_seen <= 1'b0;
    end
  end

  // responder: two-cycle latency, optional stalls
  always @(negedge clk) begin
    cyc++;
    rd_rsp_valid <= 1'b0;
    rd_req_ready <= stall ? cyc[0] : 1'b1;
    if (hs_seen) lat_left = 1;
    else if (lat_left > 0) lat_left--;
    else if (lat_left == 0) begin
      lat_left = -1;
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= (flash_q.size() > 0) ? flash_q.pop_front() : 8'h00;
    end
  end

  // every-clock comparison with the model
  task automatic cmp(string req, string nm, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", req, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("R2", "busy", AW'(busy), AW'(m_st != 0));
      cmp("R3", "rd_req_valid", AW'(rd_req_valid), AW'(m_st == 1));
      cmp("R8", "done", AW'(done), AW'(m_done));
      cmp("R8", "pass", AW'(pass), AW'(m_pass));
      cmp("R8", "fail", AW'(fail), AW'(m_fail));
      if (m_st == 1) cmp("R2", "rd_addr", rd_addr, m_addr);
    end
  end

  // ---------------- scenario helpers ----------------
  task automatic run_op(string req, bit op, logic [AW-1:0] a, logic [7:0] d,
                        bit exp_pass, int exp_reads, bit poke);
    @(negedge clk);
    start = 1; start_op = op; start_addr = a; start_data = d;
    @(negedge clk);
    start = 0;
    reads = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; start_op = !op; start_addr = ~a; start_data = ~d;
      @(negedge clk);
      start = 0;
      cmp(req, "rd_addr after ignored start", rd_addr, a);
    end
    while (!done) @(negedge clk);
    cmp(req, "verdict pass", AW'(pass), AW'(exp_pass));
    cmp(req, "verdict fail", AW'(fail), AW'(!exp_pass));
    cmp(req, "read count", AW'(reads), AW'(exp_reads));
    repeat (3) @(negedge clk);
    cmp("R8", "held done", AW'(done), AW'(1));
    cmp("R8", "held pass", AW'(pass), AW'(exp_pass));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "reset busy", AW'(busy), 0);
    cmp("R1", "reset done", AW'(done), 0);
    cmp("R1", "reset pass/fail", AW'({pass, fail}), 0);
    cmp("R1", "reset rd_req_valid", AW'(rd_req_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 program: toggles, settles, verify matches
    flash_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'h5A};
    run_op("R5", 0, 16'h1234, 8'h5A, 1, 6, 0);
    // R5 program: verify mismatch
    flash_q = '{8'h40, 8'h40, 8'h3D};
    run_op("R5", 0, 16'h0042, 8'h3C, 0, 3, 0);
    // R4 erase: immediately settled, no verify read
    flash_q = '{8'h00, 8'h00};
    run_op("R4", 1, 16'hA000, 8'h00, 1, 2, 0);
    // R6 erase: error while toggling, recheck settles
    flash_q = '{8'h00, 8'h60, 8'h60, 8'h60};
    run_op("R6", 1, 16'hA010, 8'h00, 1, 4, 0);
    // R6 erase: error, recheck still toggles
    flash_q = '{8'h40, 8'h20, 8'h60, 8'h20};
    run_op("R6", 1, 16'hA020, 8'h00, 0, 4, 0);
    // R6 program: recheck settles, then verify
    flash_q = '{8'h40, 8'h20, 8'h20, 8'h20, 8'h11};
    run_op("R6", 0, 16'h0777, 8'h11, 1, 5, 0);
    // R7 ceiling: never settles
    flash_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    run_op("R7", 1, 16'hB000, 8'h00, 0, MAXP, 0);
    // R7 boundary: settles on read number MAXP
    flash_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00};
    run_op("R7", 1, 16'hB100, 8'h00, 1, MAXP, 0);
    // R9 and R3: stalls on the request side, start pulse mid-operation
    stall = 1;
    flash_q = '{8'h00, 8'h40, 8'h40};
    run_op("R9", 1, 16'hC0DE, 8'h00, 1, 3, 1);
    flash_q = '{8'h40, 8'h00, 8'h00, 8'h99};
    run_op("R3", 0, 16'h0F0F, 8'h98, 0, 4, 0);
    stall = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    finished = 1;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule